// File: doc/BRIEF.md
# Ternary CAM Lookup Engine

This block is a small ternary content-addressable memory. It holds a table of 64 entries, each 72 bits wide. Every entry pairs a value word with a per-bit don't-care word, so each stored bit acts as 0, 1 or X. Four global mask words can also be loaded. A lookup compares a key with every entry at once. The entry don't-care bits apply, and so does one global mask that the command picks. The winning index is latched into a result register as a hit flag and a 6-bit index.

All access goes through a single command port with a 72-bit data field. It writes and reads value words, don't-care words and global masks, and it starts lookups. A narrow lookup takes one beat and compares a 72-bit key with each entry. A wide lookup compares a 144-bit key with an aligned pair of entries and takes two beats. The first beat carries the low half, which is checked against the even entry. The second beat carries the high half, which is checked against the odd entry, together with the mask select. Lookups are pipelined, and a narrow lookup can be accepted on every cycle.

The command decoder is a two-state machine. In state ST_IDLE no half key is held. In state ST_WIDE_WAIT a low half is held and waits for its partner. The transitions are:
- ARM: ST_IDLE to ST_WIDE_WAIT on a wide-low command.
- REARM: ST_WIDE_WAIT to ST_WIDE_WAIT on another wide-low command, which replaces the held half.
- FIRE: ST_WIDE_WAIT to ST_IDLE on a wide-high command, which starts the lookup.
- ABANDON: ST_WIDE_WAIT to ST_IDLE on any other defined command.
- HOLD: the state does not change when no command arrives or the opcode is undefined.

Top module: `tcam_lookup`

## Requirements
- R1: After reset, res_valid, res_hit, res_index and rd_valid are 0, and every value word, don't-care word and global mask reads back as all zeros.
- R2: Opcode 0 writes cmd_data to the value word of entry cmd_addr. Opcode 1 writes it to the don't-care word. Opcode 3 reads the value word and opcode 4 reads the don't-care word. A read accepted at one rising edge puts its word on rd_data, with rd_valid high, after the next rising edge.
- R3: Opcode 2 writes global mask number cmd_addr[1:0], and opcode 5 reads it back with the same timing as R2.
- R4: Opcode 6 is a narrow lookup of cmd_data. Key bit b matches an entry when the entry's don't-care bit b is 1, or the selected global mask bit b is 1, or the stored bit b equals key bit b. An entry matches when all 72 bits match.
- R5: When more than one entry matches, the lowest index wins. When none matches, res_hit is 0 and res_index is 0.
- R6: cmd_gsel (2 bits) on the lookup beat picks which of the four global masks takes part in the compare.
- R7: The result of a lookup appears after the second rising edge following the edge that accepts it. res_valid is high for exactly one cycle per lookup, and back-to-back narrow lookups produce one result per cycle in order.
- R8: A wide lookup is opcode 7 (low half) followed by opcode 8 (high half, with cmd_gsel). Pair k matches when entry 2k matches the low half and entry 2k+1 matches the high half. The result index is 2k, and R7 timing counts from the opcode 8 beat.
- R9: Any other defined command between opcode 7 and opcode 8 abandons the held half. An opcode 8 with no held half produces no result.
- R10: Opcodes 9 to 15 have no effect. They write nothing, read nothing, produce no result and leave a held low half in place.
- R11: A lookup sees every write accepted before it and no write accepted after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Opcode (0 to 8 defined) |
| cmd_addr | input | 6 | Entry number, or global mask number in bits 1:0 |
| cmd_gsel | input | 2 | Global mask select for lookups |
| cmd_data | input | 72 | Write data or key |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 72 | Read data |
| res_valid | output | 1 | Lookup result updated this cycle |
| res_hit | output | 1 | Result register: hit flag |
| res_index | output | 6 | Result register: winning index |

## Verification
Read data is due one rising edge after the edge that accepts the read. A lookup result is due two edges after acceptance, which for a wide lookup means two edges after its second beat. The bench drives on falling edges and notes the cycle counter at each lookup beat. It computes the expected result from a bit-by-bit model of the table and queues it as due three falling edges later. A monitor that runs on every falling edge takes each queued result only in that exact cycle, and it counts any res_valid pulse that no lookup accounts for as a failure. This is how abandoned, orphaned and undefined commands are shown to produce nothing.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

    typedef enum logic [3:0] {
        OP_WR_DATA = 4'd0,
        OP_WR_MASK = 4'd1,
        OP_WR_GM   = 4'd2,
        OP_RD_DATA = 4'd3,
        OP_RD_MASK = 4'd4,
        OP_RD_GM   = 4'd5,
        OP_LK_NAR  = 4'd6,
        OP_LK_WLO  = 4'd7,
        OP_LK_WHI  = 4'd8
    } op_e;

    typedef enum logic [0:0] {
        ST_IDLE      = 1'b0,
        ST_WIDE_WAIT = 1'b1
    } cmd_state_e;

    typedef enum logic [1:0] {
        RS_DATA = 2'd0,
        RS_MASK = 2'd1,
        RS_GM   = 2'd2
    } rd_src_e;

endpackage

// File: rtl/tcam_cmd_fsm.sv
module tcam_cmd_fsm
    import tcam_pkg::*;
#(
    parameter int KEY_W = 72,
    parameter int GS_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [3:0]       cmd_op,
    input  logic [GS_W-1:0]  cmd_gsel,
    input  logic [KEY_W-1:0] cmd_data,
    output logic             wr_data_en,
    output logic             wr_mask_en,
    output logic             wr_gm_en,
    output logic             rd_en,
    output rd_src_e          rd_src,
    output logic             lk_go,
    output logic             lk_wide,
    output logic [GS_W-1:0]  lk_gsel,
    output logic [KEY_W-1:0] lk_key_lo,
    output logic [KEY_W-1:0] lk_key_hi
);

    cmd_state_e       state, state_nxt;
    logic [KEY_W-1:0] lo_hold;
    logic             known;
    logic             take_lo;
    logic             launch_nar;
    logic             launch_wide;

    // Opcode decode
    always_comb begin
        known       = cmd_valid && (cmd_op <= OP_LK_WHI);
        wr_data_en  = known && (cmd_op == OP_WR_DATA);
        wr_mask_en  = known && (cmd_op == OP_WR_MASK);
        wr_gm_en    = known && (cmd_op == OP_WR_GM);
        rd_en       = known && ((cmd_op == OP_RD_DATA) || (cmd_op == OP_RD_MASK) ||
                                (cmd_op == OP_RD_GM));
        rd_src      = RS_DATA;
        if (cmd_op == OP_RD_MASK) rd_src = RS_MASK;
        if (cmd_op == OP_RD_GM)   rd_src = RS_GM;
        take_lo     = known && (cmd_op == OP_LK_WLO);
        launch_nar  = known && (cmd_op == OP_LK_NAR);
        launch_wide = known && (cmd_op == OP_LK_WHI) && (state == ST_WIDE_WAIT);
    end

    // Next-state logic: ARM, REARM, FIRE, ABANDON, HOLD
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:      if (take_lo) state_nxt = ST_WIDE_WAIT;          // ARM
            ST_WIDE_WAIT: if (known && !take_lo) state_nxt = ST_IDLE;     // FIRE / ABANDON
            default:      state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Held low half and lookup launch stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_hold   <= '0;
            lk_go     <= 1'b0;
            lk_wide   <= 1'b0;
            lk_gsel   <= '0;
            lk_key_lo <= '0;
            lk_key_hi <= '0;
        end else begin
            if (take_lo) lo_hold <= cmd_data;
            lk_go <= launch_nar || launch_wide;
            if (launch_nar || launch_wide) begin
                lk_wide   <= launch_wide;
                lk_gsel   <= cmd_gsel;
                lk_key_lo <= launch_wide ? lo_hold : cmd_data;
                lk_key_hi <= cmd_data;
            end
        end
    end

    assert_orphan_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_LK_WHI) && (state == ST_IDLE)) |=> !lk_go);

    assert_wide_from_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_go && lk_wide) |-> ($past(state) == ST_WIDE_WAIT));

    assert_undefined_keeps_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op > OP_LK_WHI)) |=> ($stable(state) && !lk_go));

endmodule

// File: rtl/tcam_store.sv
module tcam_store
    import tcam_pkg::*;
#(
    parameter int ENTRIES  = 64,
    parameter int KEY_W    = 72,
    parameter int GM_COUNT = 4,
    parameter int IDX_W    = 6,
    parameter int GS_W     = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_data_en,
    input  logic                            wr_mask_en,
    input  logic                            wr_gm_en,
    input  logic                            rd_en,
    input  rd_src_e                         rd_src,
    input  logic [IDX_W-1:0]                addr,
    input  logic [KEY_W-1:0]                wdata,
    output logic                            rd_valid,
    output logic [KEY_W-1:0]                rd_data,
    output logic [ENTRIES-1:0][KEY_W-1:0]   arr_data,
    output logic [ENTRIES-1:0][KEY_W-1:0]   arr_mask,
    output logic [GM_COUNT-1:0][KEY_W-1:0]  gm
);

    logic [GS_W-1:0] gm_sel;
    logic [KEY_W-1:0] rd_mux;

    assign gm_sel = addr[GS_W-1:0];

    // Per-entry value and don't-care words
    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                arr_data[e] <= '0;
                arr_mask[e] <= '0;
            end else begin
                if (wr_data_en && (addr == IDX_W'(e))) arr_data[e] <= wdata;
                if (wr_mask_en && (addr == IDX_W'(e))) arr_mask[e] <= wdata;
            end
        end
    end

    // Global mask words
    for (genvar g = 0; g < GM_COUNT; g++) begin : g_gmask
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               gm[g] <= '0;
            else if (wr_gm_en && (gm_sel == GS_W'(g))) gm[g] <= wdata;
        end
    end

    always_comb begin
        unique case (rd_src)
            RS_DATA: rd_mux = arr_data[addr];
            RS_MASK: rd_mux = arr_mask[addr];
            RS_GM:   rd_mux = gm[gm_sel];
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_mux;
        end
    end

    assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_no_stray_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

endmodule

// File: rtl/tcam_match.sv
module tcam_match #(
    parameter int ENTRIES  = 64,
    parameter int KEY_W    = 72,
    parameter int GM_COUNT = 4,
    parameter int GS_W     = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           lk_go,
    input  logic                           lk_wide,
    input  logic [GS_W-1:0]                lk_gsel,
    input  logic [KEY_W-1:0]               key_lo,
    input  logic [KEY_W-1:0]               key_hi,
    input  logic [ENTRIES-1:0][KEY_W-1:0]  arr_data,
    input  logic [ENTRIES-1:0][KEY_W-1:0]  arr_mask,
    input  logic [GM_COUNT-1:0][KEY_W-1:0] gm,
    output logic                           mv_valid,
    output logic [ENTRIES-1:0]             mv
);

    localparam int PAIRS = ENTRIES / 2;

    logic [KEY_W-1:0]   eff_gm;
    logic [ENTRIES-1:0] cmp_lo;
    logic [ENTRIES-1:0] cmp_hi;
    logic [ENTRIES-1:0] wide_hit;
    logic               mv_wide;

    assign eff_gm = gm[lk_gsel];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign cmp_lo[i] = &(arr_mask[i] | eff_gm | ~(arr_data[i] ^ key_lo));
        assign cmp_hi[i] = &(arr_mask[i] | eff_gm | ~(arr_data[i] ^ key_hi));
    end

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        assign wide_hit[2*k]   = cmp_lo[2*k] & cmp_hi[2*k+1];
        assign wide_hit[2*k+1] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mv_valid <= 1'b0;
            mv_wide  <= 1'b0;
            mv       <= '0;
        end else begin
            mv_valid <= lk_go;
            if (lk_go) begin
                mv_wide <= lk_wide;
                mv      <= lk_wide ? wide_hit : cmp_lo;
            end
        end
    end

    assert_stage_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_go |=> mv_valid);

    assert_stage_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_go |=> !mv_valid);

    assert_wide_even_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_valid && mv_wide) |-> ((mv & {PAIRS{2'b10}}) == '0));

endmodule

// File: rtl/tcam_prio.sv
module tcam_prio #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mv_valid,
    input  logic [ENTRIES-1:0] mv,
    output logic               res_valid,
    output logic               res_hit,
    output logic [IDX_W-1:0]   res_index
);

    logic [IDX_W-1:0] enc;

    // Lowest set bit wins
    always_comb begin
        enc = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (mv[i]) enc = IDX_W'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_index <= '0;
        end else begin
            res_valid <= mv_valid;
            if (mv_valid) begin
                res_hit   <= |mv;
                res_index <= (|mv) ? enc : '0;
            end
        end
    end

    assert_hit_is_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> ((($past(mv) >> res_index) & ENTRIES'(1)) != '0));

    assert_hit_is_lowest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |->
            (($past(mv) & ((ENTRIES'(1) << res_index) - ENTRIES'(1))) == '0));

    assert_miss_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (($past(mv) == '0) && (res_index == '0)));

endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup
    import tcam_pkg::*;
#(
    parameter int ENTRIES  = 64,
    parameter int KEY_W    = 72,
    parameter int GM_COUNT = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_valid,
    input  logic [3:0]                    cmd_op,
    input  logic [$clog2(ENTRIES)-1:0]    cmd_addr,
    input  logic [$clog2(GM_COUNT)-1:0]   cmd_gsel,
    input  logic [KEY_W-1:0]              cmd_data,
    output logic                          rd_valid,
    output logic [KEY_W-1:0]              rd_data,
    output logic                          res_valid,
    output logic                          res_hit,
    output logic [$clog2(ENTRIES)-1:0]    res_index
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int GS_W  = $clog2(GM_COUNT);

    logic                           wr_data_en, wr_mask_en, wr_gm_en, rd_en;
    rd_src_e                        rd_src;
    logic                           lk_go, lk_wide;
    logic [GS_W-1:0]                lk_gsel;
    logic [KEY_W-1:0]               lk_key_lo, lk_key_hi;
    logic [ENTRIES-1:0][KEY_W-1:0]  arr_data, arr_mask;
    logic [GM_COUNT-1:0][KEY_W-1:0] gm;
    logic                           mv_valid;
    logic [ENTRIES-1:0]             mv;

    tcam_cmd_fsm #(.KEY_W(KEY_W), .GS_W(GS_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_gsel(cmd_gsel), .cmd_data(cmd_data),
        .wr_data_en(wr_data_en), .wr_mask_en(wr_mask_en), .wr_gm_en(wr_gm_en),
        .rd_en(rd_en), .rd_src(rd_src), .lk_go(lk_go), .lk_wide(lk_wide),
        .lk_gsel(lk_gsel), .lk_key_lo(lk_key_lo), .lk_key_hi(lk_key_hi)
    );

    tcam_store #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .GM_COUNT(GM_COUNT),
                 .IDX_W(IDX_W), .GS_W(GS_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_data_en(wr_data_en), .wr_mask_en(wr_mask_en),
        .wr_gm_en(wr_gm_en), .rd_en(rd_en), .rd_src(rd_src), .addr(cmd_addr),
        .wdata(cmd_data), .rd_valid(rd_valid), .rd_data(rd_data),
        .arr_data(arr_data), .arr_mask(arr_mask), .gm(gm)
    );

    tcam_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .GM_COUNT(GM_COUNT),
                 .GS_W(GS_W)) u_match (
        .clk(clk), .rst_n(rst_n), .lk_go(lk_go), .lk_wide(lk_wide),
        .lk_gsel(lk_gsel), .key_lo(lk_key_lo), .key_hi(lk_key_hi),
        .arr_data(arr_data), .arr_mask(arr_mask), .gm(gm),
        .mv_valid(mv_valid), .mv(mv)
    );

    tcam_prio #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_prio (
        .clk(clk), .rst_n(rst_n), .mv_valid(mv_valid), .mv(mv),
        .res_valid(res_valid), .res_hit(res_hit), .res_index(res_index)
    );

    assert_result_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_go |=> ##1 res_valid);

endmodule

// File: tb/sim_tcam_lookup.sv
`timescale 1ns/1ps
module sim_tcam_lookup;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [5:0]  cmd_addr = '0;
    logic [1:0]  cmd_gsel = '0;
    logic [71:0] cmd_data = '0;
    logic        rd_valid;
    logic [71:0] rd_data;
    logic        res_valid;
    logic        res_hit;
    logic [5:0]  res_index;

    always #5 clk = ~clk;

    tcam_lookup u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_gsel(cmd_gsel), .cmd_data(cmd_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .res_valid(res_valid),
        .res_hit(res_hit), .res_index(res_index)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int spurious = 0;
    bit finished = 0;

    logic [71:0] sd [64];
    logic [71:0] sm [64];
    logic [71:0] sg [4];

    typedef struct { int due; bit hit; int idx; string tag; } exp_t;
    exp_t q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, logic [71:0] act, logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit entry_ok(int e, logic [71:0] k, int gs);
        for (int b = 0; b < 72; b++)
            if (!(sm[e][b] || sg[gs][b] || (sd[e][b] == k[b]))) return 1'b0;
        return 1'b1;
    endfunction

    function automatic void model(bit wide, logic [71:0] klo, logic [71:0] khi, int gs,
                                  output bit hit, output int idx);
        hit = 0; idx = 0;
        for (int i = 0; i < 64; i++) begin
            bit m;
            if (wide) m = (i % 2 == 0) && entry_ok(i, klo, gs) && entry_ok(i + 1, khi, gs);
            else      m = entry_ok(i, klo, gs);
            if (m && !hit) begin hit = 1; idx = i; end
        end
    endfunction

    // Result monitor: each queued result is due in exactly one cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                check({q[0].tag, " res_valid"}, 72'(res_valid), 72'(1));
                check({q[0].tag, " res_hit"}, 72'(res_hit), 72'(q[0].hit));
                check({q[0].tag, " res_index"}, 72'(res_index), 72'(q[0].idx));
                void'(q.pop_front());
            end else if (res_valid) begin
                spurious++;
                checks++;
                errors++;
                $display("FAIL R7/R9/R10 unexpected result: actual hit=%0d idx=%0d expected none",
                         res_hit, res_index);
            end
        end
    end

    task automatic drive(logic [3:0] op, int addr, int gs, logic [71:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr[5:0]; cmd_gsel = gs[1:0]; cmd_data = d;
    endtask

    task automatic idle_cmd();
        cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_gsel = '0; cmd_data = '0;
    endtask

    task automatic wr(logic [3:0] op, int addr, logic [71:0] d);
        drive(op, addr, 0, d);
        if (op == 4'd0) sd[addr] = d;
        if (op == 4'd1) sm[addr] = d;
        if (op == 4'd2) sg[addr % 4] = d;
        @(negedge clk);
        idle_cmd();
    endtask

    task automatic rd_chk(logic [3:0] op, int addr, logic [71:0] exp, string tag);
        drive(op, addr, 0, '0);
        @(negedge clk);
        idle_cmd();
        check({tag, " rd_valid"}, 72'(rd_valid), 72'(1));
        check({tag, " rd_data"}, rd_data, exp);
    endtask

    task automatic look(logic [71:0] k, int gs, string tag);
        bit h; int ix;
        drive(4'd6, 0, gs, k);
        model(0, k, '0, gs, h, ix);
        q.push_back('{cyc + 3, h, ix, tag});
        @(negedge clk);
        idle_cmd();
    endtask

    task automatic look_wide(logic [71:0] klo, logic [71:0] khi, int gs, string tag);
        bit h; int ix;
        drive(4'd7, 0, 0, klo);
        @(negedge clk);
        drive(4'd8, 0, gs, khi);
        model(1, klo, khi, gs, h, ix);
        q.push_back('{cyc + 3, h, ix, tag});
        @(negedge clk);
        idle_cmd();
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    function automatic logic [71:0] pat(int i);
        return {8'(i * 29 + 3), 32'(i) * 32'h9E3779B1, 32'(i + 7) * 32'h85EBCA6B};
    endfunction

    initial begin
        repeat (2000) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin sd[i] = '0; sm[i] = '0; end
        for (int g = 0; g < 4; g++) sg[g] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 res_valid", 72'(res_valid), 72'(0));
        check("R1 res_hit", 72'(res_hit), 72'(0));
        check("R1 res_index", 72'(res_index), 72'(0));
        check("R1 rd_valid", 72'(rd_valid), 72'(0));
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk(4'd3, 17, '0, "R1 data after reset");
        rd_chk(4'd4, 63, '0, "R1 mask after reset");
        rd_chk(4'd5, 2, '0, "R1 gmask after reset");

        // Load table: entry 50 duplicates entry 12; entries 5,13,21.. have low don't-cares
        for (int i = 0; i < 64; i++) wr(4'd0, i, (i == 50) ? pat(12) : pat(i));
        for (int i = 0; i < 64; i++) if (i % 8 == 5) wr(4'd1, i, 72'hFFF);
        wr(4'd2, 1, {72{1'b1}});
        wr(4'd2, 2, 72'hFFFF_FFFF);
        wr(4'd2, 7, {8'hFF, 64'h0});   // address bits 1:0 select mask 3

        // R2 / R3: readback
        for (int i = 0; i < 64; i++) rd_chk(4'd3, i, sd[i], "R2 data readback");
        for (int i = 0; i < 64; i += 3) rd_chk(4'd4, i, sm[i], "R2 mask readback");
        for (int g = 0; g < 4; g++) rd_chk(4'd5, g, sg[g], "R3 gmask readback");

        // R4 / R5 / R7: back-to-back narrow sweep of stored keys
        for (int i = 0; i < 64; i++) look(sd[i], 0, "R4 R5 R7 exact key");
        settle();
        // R4: single-bit perturbations, hit only where the bit is don't-care
        for (int i = 0; i < 64; i++) look(sd[i] ^ (72'h1 << (i % 72)), 0, "R4 perturbed key");
        for (int i = 0; i < 64; i++) look(sd[i] ^ (72'h1 << ((i * 7) % 12)), 0, "R4 low bits");
        settle();
        // R6: global mask select
        for (int i = 0; i < 64; i++)
            look(sd[i] ^ {8'(i), 32'h0, 32'(i * 3 + 1)}, i % 4, "R6 gmask select");
        look(72'h0, 1, "R6 all-ignore mask hits lowest");
        settle();
        // R8: wide lookups
        for (int k = 0; k < 32; k++) look_wide(sd[2 * k], sd[2 * k + 1], 0, "R8 wide pair");
        for (int k = 0; k < 31; k++) look_wide(sd[2 * k], sd[2 * k + 3], 0, "R8 wide mismatch");
        look_wide(sd[1], sd[2], 0, "R8 odd alignment miss");
        look_wide(sd[20] ^ 72'h1, sd[21], 2, "R8 wide gmask from high beat");
        settle();

        // R9: intervening read abandons, orphan high beat ignored
        drive(4'd7, 0, 0, sd[0]);
        @(negedge clk);
        rd_chk(4'd3, 5, sd[5], "R9 intervening read");
        drive(4'd8, 0, 0, sd[1]);
        @(negedge clk);
        idle_cmd();
        settle();
        check("R9 no result from abandoned pair", 72'(spurious), 72'(0));

        // R10: undefined opcode keeps held half and changes nothing
        begin
            bit h; int ix;
            drive(4'd7, 0, 0, sd[2]);
            @(negedge clk);
            drive(4'd12, 3, 0, {72{1'b1}});
            @(negedge clk);
            drive(4'd8, 0, 0, sd[3]);
            model(1, sd[2], sd[3], 0, h, ix);
            q.push_back('{cyc + 3, h, ix, "R10 pair survives undefined op"});
            @(negedge clk);
            idle_cmd();
        end
        drive(4'd15, 9, 0, {72{1'b1}});
        @(negedge clk);
        idle_cmd();
        settle();
        rd_chk(4'd3, 3, sd[3], "R10 entry 3 untouched");
        rd_chk(4'd4, 9, sm[9], "R10 mask 9 untouched");
        check("R10 no result from undefined op", 72'(spurious), 72'(0));

        // R11: write then lookup at once, lookup then write at once
        wr(4'd1, 7, {72{1'b1}});
        look(sd[30], 0, "R11 sees earlier write");
        look(sd[40], 0, "R11 second lookup");
        wr(4'd1, 3, {72{1'b1}});
        wr(4'd1, 7, '0);
        wr(4'd1, 3, '0);
        look(sd[30], 0, "R11 after restore");
        settle();

        check("R7 all results delivered", 72'(q.size()), 72'(0));
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule